// File: doc/BRIEF.md
# Packet Bit Selector Signal Logic

This block listens to a byte-serial packet stream and turns occupancy bits carried by other nodes' packets into red/yellow/green signal aspects. Each beat presents one byte with start and end markers. On the end-of-packet beat a flag reports whether the packet's checksum was good. The byte position inside a packet fixes its meaning. Position 0 is the sender address, position 1 the destination and positions 2 and 3 the checksum. Position 4 is the length and position 5 the packet type, and payload starts at position 6.

Each signal direction has two watch channels, one for the immediate block and one for the adjacent block. A channel is configured with a sender address, a packet type and a packed selector byte. Selector bits 7:5 give a bit number and bits 4:0 give a byte position counted from the sender address. For example, sender 0x12, type 0x44 and selector 0x26 pick bit 1 of byte 6. When a good packet matches, the channel keeps that bit. Between matching packets the kept bit holds its value, and the node never issues queries.

The kept bits decide the aspect of each direction. The aspects are packed into one status byte, and a one-cycle pulse marks every change of that byte.

Top module: `pbs_aspect_top`

## Requirements
- R1: After reset the status byte reads 0x11 (both directions green) and the change pulse is low. The status byte holds that value until a qualifying packet changes it.
- R2: A packet qualifies for a channel when all of these hold: its byte 0 equals the channel's sender address, its byte 5 equals the channel's type, and the checksum flag is high on the end beat. The channel then keeps bit `sel[7:5]` of byte `sel[4:0]`, where byte 0 is the first byte after start.
- R3: A packet whose checksum flag is low on its end beat changes no kept bit.
- R4: A packet whose sender address or type differs from a channel's configuration leaves that channel's kept bit unchanged.
- R5: A packet whose length byte (byte 4) differs from the number of bytes actually received leaves every kept bit unchanged.
- R6: If the selected byte position is not present in the packet, the channel's kept bit is unchanged.
- R7: For each direction, the aspect code is 0x4 (red) when the immediate bit is 1. It is 0x2 (yellow) when only the adjacent bit is 1, and 0x1 (green) when both are 0.
- R8: Status bits 7:4 carry the eastbound aspect and bits 3:0 the westbound aspect. The channels are numbered 0 to 3 as westbound immediate, westbound adjacent, eastbound immediate and eastbound adjacent. Configuration byte k of each config port belongs to channel k.
- R9: The status byte takes its new value at the second rising edge after the end beat. The change pulse is high for exactly the one cycle in which the status byte holds a value that differs from its previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_byte | input | 8 | Packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_crc_ok | input | 1 | Checksum good, meaningful on the end beat |
| cfg_src | input | 32 | Sender address per channel, byte k for channel k |
| cfg_type | input | 32 | Packet type per channel |
| cfg_sel | input | 32 | Packed bit/byte selector per channel |
| status | output | 8 | Eastbound aspect in bits 7:4, westbound in bits 3:0 |
| status_chg | output | 1 | One-cycle pulse on every status change |

## Verification
The assertions assume that reset is held low from time zero and that the checksum flag is only acted on together with a valid end beat. They also assume that configuration stays constant while packets flow, so a status change can always be traced to a good end beat two edges earlier. The bench sets the configuration once before reset is released, never changes it, and drives every packet as consecutive valid beats with the start and end flags each on exactly one beat.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   // Fixed header positions; channels and length checking depend on them.
   localparam int HDR_SRC  = 0;
   localparam int HDR_LEN  = 4;
   localparam int HDR_TYPE = 5;

   localparam logic [3:0] ASP_GREEN  = 4'h1;
   localparam logic [3:0] ASP_YELLOW = 4'h2;
   localparam logic [3:0] ASP_RED    = 4'h4;

   typedef struct packed {
      logic [2:0] bit_no;
      logic [4:0] byte_no;
   } sel_t;

   function automatic logic [3:0] pick_aspect(input logic imd, input logic adj);
      if (imd)      return ASP_RED;
      else if (adj) return ASP_YELLOW;
      else          return ASP_GREEN;
   endfunction

endpackage

// File: rtl/pbs_frame_track.sv
module pbs_frame_track
   import pbs_pkg::*;
#(
   parameter int IDX_W     = 6,
   parameter bit LEN_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic             in_crc_ok,
   output logic             beat,
   output logic [IDX_W-1:0] cur_idx,
   output logic [7:0]       src_now,
   output logic [7:0]       type_now,
   output logic             commit
);

   localparam logic [IDX_W-1:0] I_SRC  = IDX_W'(HDR_SRC);
   localparam logic [IDX_W-1:0] I_LEN  = IDX_W'(HDR_LEN);
   localparam logic [IDX_W-1:0] I_TYPE = IDX_W'(HDR_TYPE);
   localparam logic [IDX_W-1:0] I_SAT  = {IDX_W{1'b1}};

   logic [IDX_W-1:0] cnt_q;
   logic             active_q;
   logic [7:0]       src_q, type_q, len_q;
   logic [7:0]       len_now;
   logic             len_ok;
   logic             hdr_seen;
   logic             sat;

   assign beat     = in_valid && (in_sop || active_q);
   assign cur_idx  = in_sop ? '0 : cnt_q;
   assign sat      = (cur_idx == I_SAT);
   assign src_now  = (beat && cur_idx == I_SRC)  ? in_byte : src_q;
   assign type_now = (beat && cur_idx == I_TYPE) ? in_byte : type_q;
   assign len_now  = (beat && cur_idx == I_LEN)  ? in_byte : len_q;
   assign hdr_seen = (cur_idx >= I_TYPE);

   generate
      if (LEN_CHECK) begin : g_len_chk
         assign len_ok = !sat && (len_now == (8'(cur_idx) + 8'd1));
      end else begin : g_len_free
         assign len_ok = 1'b1;
      end
   endgenerate

   assign commit = beat && in_eop && in_crc_ok && hdr_seen && len_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         src_q    <= '0;
         type_q   <= '0;
         len_q    <= '0;
      end else if (beat) begin
         cnt_q    <= sat ? cur_idx : cur_idx + 1'b1;
         active_q <= !in_eop;
         src_q    <= src_now;
         type_q   <= type_now;
         len_q    <= len_now;
      end
   end

endmodule

// File: rtl/pbs_chan.sv
module pbs_chan
   import pbs_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             in_sop,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [7:0]       in_byte,
   input  logic             commit,
   input  logic [7:0]       src_now,
   input  logic [7:0]       type_now,
   input  logic [7:0]       cfg_src,
   input  logic [7:0]       cfg_type,
   input  logic [7:0]       cfg_sel,
   output logic             held
);

   sel_t             sel;
   logic [IDX_W-1:0] off;
   logic             at_sel;
   logic             got_q, got_now;
   logic             cand_q, cand_now;
   logic             match;

   assign sel      = sel_t'(cfg_sel);
   assign off      = IDX_W'(sel.byte_no);
   assign at_sel   = beat && (cur_idx == off);
   assign got_now  = (in_sop ? 1'b0 : got_q) | at_sel;
   assign cand_now = at_sel ? in_byte[sel.bit_no] : cand_q;
   assign match    = (src_now == cfg_src) && (type_now == cfg_type);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         got_q  <= 1'b0;
         cand_q <= 1'b0;
         held   <= 1'b0;
      end else begin
         if (beat) begin
            got_q  <= got_now;
            cand_q <= cand_now;
         end
         if (commit && match && got_now)
            held <= cand_now;
      end
   end

endmodule

// File: rtl/pbs_status_reg.sv
module pbs_status_reg
   import pbs_pkg::*;
#(
   parameter int N_DIR = 2,
   localparam int ST_W = 4 * N_DIR
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_DIR-1:0] imd,
   input  logic [N_DIR-1:0] adj,
   output logic [ST_W-1:0] status,
   output logic            status_chg
);

   logic [ST_W-1:0] next_st;

   generate
      for (genvar d = 0; d < N_DIR; d++) begin : g_dir
         assign next_st[4*d +: 4] = pick_aspect(imd[d], adj[d]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status     <= {N_DIR{ASP_GREEN}};
         status_chg <= 1'b0;
      end else begin
         status     <= next_st;
         status_chg <= (next_st != status);
      end
   end

endmodule

// File: rtl/pbs_aspect_top.sv
module pbs_aspect_top
   import pbs_pkg::*;
#(
   parameter int N_DIR     = 2,
   parameter int MAX_BYTES = 32,
   parameter bit LEN_CHECK = 1'b1,
   localparam int N_CH  = 2 * N_DIR,
   localparam int ST_W  = 4 * N_DIR,
   localparam int IDX_W = $clog2(MAX_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_crc_ok,
   input  logic [8*N_CH-1:0] cfg_src,
   input  logic [8*N_CH-1:0] cfg_type,
   input  logic [8*N_CH-1:0] cfg_sel,
   output logic [ST_W-1:0]   status,
   output logic              status_chg
);

   generate
      if (N_DIR < 1)
         $error("pbs_aspect_top: N_DIR must be at least 1");
      if (MAX_BYTES < 32 || MAX_BYTES > 128)
         $error("pbs_aspect_top: MAX_BYTES must lie in 32..128");
   endgenerate

   logic             beat;
   logic [IDX_W-1:0] cur_idx;
   logic [7:0]       src_now, type_now;
   logic             commit;
   logic [N_CH-1:0]  held;
   logic [N_DIR-1:0] imd, adj;

   pbs_frame_track #(.IDX_W(IDX_W), .LEN_CHECK(LEN_CHECK)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .in_crc_ok(in_crc_ok),
      .beat     (beat),
      .cur_idx  (cur_idx),
      .src_now  (src_now),
      .type_now (type_now),
      .commit   (commit)
   );

   generate
      for (genvar k = 0; k < N_CH; k++) begin : g_ch
         pbs_chan #(.IDX_W(IDX_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .beat    (beat),
            .in_sop  (in_sop),
            .cur_idx (cur_idx),
            .in_byte (in_byte),
            .commit  (commit),
            .src_now (src_now),
            .type_now(type_now),
            .cfg_src (cfg_src[8*k +: 8]),
            .cfg_type(cfg_type[8*k +: 8]),
            .cfg_sel (cfg_sel[8*k +: 8]),
            .held    (held[k])
         );
      end
      for (genvar d = 0; d < N_DIR; d++) begin : g_pair
         assign imd[d] = held[2*d];
         assign adj[d] = held[2*d+1];
      end
   endgenerate

   pbs_status_reg #(.N_DIR(N_DIR)) u_st (
      .clk       (clk),
      .rst_n     (rst_n),
      .imd       (imd),
      .adj       (adj),
      .status    (status),
      .status_chg(status_chg)
   );

endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
   parameter int ST_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_eop,
   input logic            in_crc_ok,
   input logic [ST_W-1:0] status,
   input logic            status_chg
);

   // R1: first cycle out of reset shows all directions green
   p_reset_green_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (status == {(ST_W/4){4'h1}} && !status_chg));

   // R7: each nibble is a legal one-hot aspect code
   p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(status[3:0]) && !status[3] && $onehot(status[ST_W-1 -: 4]) && !status[ST_W-1]);

   // R9: a pulse only accompanies an actual change
   p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status_chg |-> (status != $past(status)));

   // R9: every change is flagged
   p_change_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status != $past(status)) |-> status_chg);

   // R3: a change needs a good end beat two edges before
   p_change_needs_good_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status != $past(status)) |-> $past(in_valid && in_eop && in_crc_ok, 2));

endmodule

bind pbs_aspect_top pbs_chk #(.ST_W(ST_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_eop    (in_eop),
   .in_crc_ok (in_crc_ok),
   .status    (status),
   .status_chg(status_chg)
);

// File: tb/pbs_aspect_top_tb.sv
`timescale 1ns/1ps
module pbs_aspect_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        in_crc_ok = 1'b0;
   logic [31:0] cfg_src, cfg_type, cfg_sel;
   logic [7:0]  status;
   logic        status_chg;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // R8: channel order west imd, west adj, east imd, east adj
   assign cfg_src  = {8'h13, 8'h12, 8'h11, 8'h12};
   assign cfg_type = {8'h44, 8'h44, 8'h44, 8'h44};
   assign cfg_sel  = {8'h07, 8'h46, 8'h06, 8'h26};

   pbs_aspect_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_sop(in_sop), .in_eop(in_eop), .in_crc_ok(in_crc_ok),
      .cfg_src(cfg_src), .cfg_type(cfg_type), .cfg_sel(cfg_sel),
      .status(status), .status_chg(status_chg)
   );

   always @(posedge clk) if (rst_n && status_chg) pulses <= pulses + 1;

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // fields: src, type, len byte, beats, byte6, byte7, crc, expected status, tag
   localparam int NV = 12;
   localparam logic [56:0] VEC [NV] = '{
      {8'h12, 8'h44, 8'd7, 8'd7, 8'h04, 8'h00, 1'b1, 8'h41}, // R2 R8 east red
      {8'h11, 8'h44, 8'd7, 8'd7, 8'h01, 8'h00, 1'b1, 8'h42}, // R7 west yellow
      {8'h12, 8'h44, 8'd7, 8'd7, 8'h06, 8'h00, 1'b1, 8'h44}, // R7 red beats yellow
      {8'h12, 8'h44, 8'd7, 8'd7, 8'h00, 8'h00, 1'b0, 8'h44}, // R3 bad checksum
      {8'h12, 8'h53, 8'd7, 8'd7, 8'h00, 8'h00, 1'b1, 8'h44}, // R4 type mismatch
      {8'h14, 8'h44, 8'd7, 8'd7, 8'h00, 8'h00, 1'b1, 8'h44}, // R4 source mismatch
      {8'h12, 8'h44, 8'd8, 8'd7, 8'h00, 8'h00, 1'b1, 8'h44}, // R5 length mismatch
      {8'h12, 8'h44, 8'd7, 8'd7, 8'h00, 8'h00, 1'b1, 8'h12}, // R2 clears
      {8'h13, 8'h44, 8'd8, 8'd8, 8'h00, 8'h01, 1'b1, 8'h22}, // R2 byte 7
      {8'h13, 8'h44, 8'd7, 8'd7, 8'hFF, 8'h00, 1'b1, 8'h22}, // R6 absent byte
      {8'h11, 8'h44, 8'd7, 8'd7, 8'h00, 8'h00, 1'b1, 8'h21}, // R7 west green
      {8'h13, 8'h44, 8'd8, 8'd8, 8'h00, 8'h00, 1'b1, 8'h11}  // R7 both green
   };

   task automatic send(input logic [7:0] src, input logic [7:0] typ, input logic [7:0] lenf,
                       input int n, input logic [7:0] d6, input logic [7:0] d7, input logic crc);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_sop    = (i == 0);
         in_eop    = (i == n - 1);
         in_crc_ok = crc && (i == n - 1);
         case (i)
            0: in_byte = src;
            1: in_byte = 8'hFF;
            2: in_byte = 8'hA5;
            3: in_byte = 8'h5A;
            4: in_byte = lenf;
            5: in_byte = typ;
            6: in_byte = d6;
            7: in_byte = d7;
            default: in_byte = 8'h00;
         endcase
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_crc_ok = 1'b0; in_byte = '0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] prev;
      int p0;
      repeat (3) @(negedge clk);
      check(status, 8'h11, "R1 reset status");
      check({7'd0, status_chg}, 8'h00, "R1 reset pulse");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(status, 8'h11, "R1 idle after reset");

      prev = 8'h11;
      for (int v = 0; v < NV; v++) begin
         p0 = pulses;
         send(VEC[v][56:49], VEC[v][48:41], VEC[v][40:33], int'(VEC[v][32:25]),
              VEC[v][24:17], VEC[v][16:9], VEC[v][8]);
         repeat (3) @(negedge clk);
         check(status, VEC[v][7:0], $sformatf("R2-table vector %0d status", v));
         check(8'(pulses - p0), (VEC[v][7:0] != prev) ? 8'd1 : 8'd0,
               $sformatf("R9 vector %0d pulse count", v));
         prev = VEC[v][7:0];
      end

      // R9: exact latency and single-cycle pulse
      send(8'h12, 8'h44, 8'd7, 7, 8'h04, 8'h00, 1'b1);
      check(status, 8'h11, "R9 status before second edge");
      check({7'd0, status_chg}, 8'h00, "R9 pulse before second edge");
      @(negedge clk);
      check(status, 8'h41, "R9 status at second edge");
      check({7'd0, status_chg}, 8'h01, "R9 pulse high");
      @(negedge clk);
      check({7'd0, status_chg}, 8'h00, "R9 pulse one cycle");

      // R1: reset mid-run restores green
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(status, 8'h11, "R1 reset after activity");
      check({7'd0, status_chg}, 8'h00, "R1 no pulse after reset");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule